// File: doc/BRIEF.md
# Oversampling accumulation controller

This block builds one averaged result for a single regular channel out of a burst of successive converter samples. It issues start-of-conversion requests to the converter, adds each accepted sample into one shared accumulator, and after the programmed number of samples it presents the sum shifted right together with a one-cycle end-of-conversion pulse.

The start of a burst is gated by an external trigger. A per-sample trigger mode makes every conversion of the burst wait for its own trigger. A burst-gate bit chooses between one trigger per burst and bursts that repeat back to back. An abort pulse models a higher-priority conversion that preempts the regular one. A restart-mode bit chooses whether the partial sum survives the preemption or is thrown away.

Top module: `adc_ovs_ctrl`

## Requirements
- R1: While `per_smp_trig_i` is 1, the block behaves as though `burst_gate_i` were 1, whatever value `burst_gate_i` has.
- R2: With `per_smp_trig_i`=0 and `burst_gate_i`=1, one trigger pulse produces exactly N conversion requests. Each request after the first is issued in the cycle after the previous sample is accepted. After the Nth sample the block returns to idle.
- R3: With `per_smp_trig_i`=1, every `conv_start_o` pulse comes in the cycle after a cycle in which `trig_i` was 1.
- R4: `eoc_o` is a one-cycle pulse in the cycle after the Nth accepted sample. `avg_o` changes only in that cycle and holds its value otherwise. Both outputs are 0 after reset.
- R5: With `restart_on_abort_i`=0, an abort discards only the conversion in flight. The partial sum and sample count are kept. In the burst mode the lost conversion is requested again in the next cycle.
- R6: With `restart_on_abort_i`=1, an abort clears the partial sum and the sample count, so that all N samples of a result come from one uninterrupted run.
- R7: With `restart_on_abort_i`=1, if aborts keep arriving more often than a whole burst takes, no result is ever produced. Conversion requests continue, and a result follows once the aborts stop.
- R8: With `per_smp_trig_i`=0 and `burst_gate_i`=0, bursts repeat after one trigger without any further trigger. Setting `burst_gate_i` to 1 stops the repetition after the current burst.
- R9: `ratio_sel_i` = k (0 to 7) selects N = 2^(k+1) samples per result, so the ratio runs from 2 to 256.
- R10: `avg_o` is the low 16 bits of the 20-bit sum shifted right by `shift_i`, with truncation. Shift values above 8 act as 8. The sum never overflows.
- R11: An abort in the same cycle as `smp_valid_i` wins, and that sample is not accumulated.
- R12: A trigger that arrives while a conversion of the burst is in flight has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | External trigger pulse |
| smp_valid_i | input | 1 | Converter sample strobe |
| smp_data_i | input | 12 | Converter sample value |
| abort_i | input | 1 | Preemption of the regular conversion in flight |
| per_smp_trig_i | input | 1 | 1: every sample of the burst waits for a trigger |
| burst_gate_i | input | 1 | 1: each burst waits for a trigger; 0: bursts repeat |
| restart_on_abort_i | input | 1 | 1: abort clears the partial sum; 0: abort keeps it |
| ratio_sel_i | input | 3 | Ratio code k, N = 2^(k+1) |
| shift_i | input | 4 | Right shift applied to the sum (0 to 8) |
| conv_start_o | output | 1 | Conversion request pulse |
| avg_o | output | 16 | Averaged result |
| eoc_o | output | 1 | Result-ready pulse |

## Verification
The hardest cases to reach are an abort that lands on exactly the cycle in which a sample is strobed, and a train of aborts sustained long enough to show that the restart mode starves the result. The bench places its converter model behind the request output. Scenario tasks watch the strobe from the falling edge and raise the abort in the same cycle as the strobe, or in a cycle when no sample is present. A running model of the expected sum, built only from the accepted samples and the aborts, checks every result pulse and confirms that no result appears while the abort train lasts.

// File: rtl/adc_ovs_pkg.sv
package adc_ovs_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_CONV = 2'd1,
      SEQ_WAIT = 2'd2
   } seq_state_e;

endpackage

// File: rtl/adc_ovs_seq.sv
module adc_ovs_seq
   import adc_ovs_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic trig_i,
   input  logic smp_valid_i,
   input  logic abort_i,
   input  logic per_smp_trig_i,
   input  logic burst_gate_i,
   input  logic restart_on_abort_i,
   input  logic done_i,
   output logic start_o,
   output logic add_o,
   output logic clr_o
);

   seq_state_e state_q, state_d;
   logic       start_d;
   logic       gate_eff;

   // Per-sample triggering forces the burst gate on
   assign gate_eff = burst_gate_i | per_smp_trig_i;
   assign clr_o    = abort_i & restart_on_abort_i;

   always_comb begin
      state_d = state_q;
      start_d = 1'b0;
      add_o   = 1'b0;
      unique case (state_q)
         SEQ_IDLE: begin
            if (trig_i) begin
               state_d = SEQ_CONV;
               start_d = 1'b1;
            end
         end
         SEQ_CONV: begin
            if (abort_i) begin
               if (per_smp_trig_i) state_d = SEQ_WAIT;
               else                start_d = 1'b1;
            end else if (smp_valid_i) begin
               add_o = 1'b1;
               if (done_i) begin
                  if (gate_eff) state_d = SEQ_IDLE;
                  else          start_d = 1'b1;
               end else if (per_smp_trig_i) begin
                  state_d = SEQ_WAIT;
               end else begin
                  start_d = 1'b1;
               end
            end
         end
         SEQ_WAIT: begin
            if (trig_i) begin
               state_d = SEQ_CONV;
               start_d = 1'b1;
            end
         end
         default: state_d = SEQ_IDLE;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q <= SEQ_IDLE;
         start_o <= 1'b0;
      end else begin
         state_q <= state_d;
         start_o <= start_d;
      end
   end

   // R3 / R1: per-sample mode never requests a conversion without a trigger
   p_trig_only_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_o && $past(per_smp_trig_i)) |-> $past(trig_i));

   // R12: a trigger during an in-flight conversion does not raise a request
   p_trig_ignored_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == SEQ_CONV && trig_i && !abort_i && !smp_valid_i) |=> !start_o);

endmodule

// File: rtl/adc_ovs_acc.sv
module adc_ovs_acc #(
   parameter int DATA_W    = 12,
   parameter int LOG2_MAX  = 8,
   parameter int ACC_W     = 20,
   parameter int SEL_W     = 3
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              add_i,
   input  logic              clr_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic [SEL_W-1:0]  ratio_sel_i,
   output logic              done_o,
   output logic [ACC_W-1:0]  sum_o
);

   localparam int CNT_W = LOG2_MAX;

   logic [ACC_W-1:0] acc_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W:0]   last_w;

   // Index of the final sample: 2^(k+1) - 1
   assign last_w = (CNT_W+1)'((32'd1 << (32'(ratio_sel_i) + 32'd1)) - 32'd1);
   assign sum_o  = acc_q + ACC_W'(data_i);
   assign done_o = add_i && ({1'b0, cnt_q} >= last_w);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         acc_q <= '0;
         cnt_q <= '0;
      end else if (clr_i || done_o) begin
         acc_q <= '0;
         cnt_q <= '0;
      end else if (add_i) begin
         acc_q <= sum_o;
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   // R6: restart mode wipes the partial state
   p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (cnt_q == '0 && acc_q == '0));

   // R5: with no accepted sample and no clear, the partial state is kept
   p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!add_i && !clr_i) |=> ($stable(cnt_q) && $stable(acc_q)));

   // R9: the count starts over after a completed burst
   p_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> (cnt_q == '0));

endmodule

// File: rtl/adc_ovs_shift.sv
module adc_ovs_shift #(
   parameter int IN_W      = 20,
   parameter int OUT_W     = 16,
   parameter int SH_W      = 4,
   parameter int MAX_SHIFT = 8
) (
   input  logic [IN_W-1:0]  din_i,
   input  logic [SH_W-1:0]  sh_i,
   output logic [OUT_W-1:0] dout_o
);

   logic [SH_W-1:0] sh_c;
   logic [IN_W-1:0] stg [SH_W+1];

   assign sh_c   = (sh_i > SH_W'(MAX_SHIFT)) ? SH_W'(MAX_SHIFT) : sh_i;
   assign stg[0] = din_i;

   for (genvar i = 0; i < SH_W; i++) begin : g_stage
      assign stg[i+1] = sh_c[i] ? (stg[i] >> (2**i)) : stg[i];
   end

   if (OUT_W <= IN_W) begin : g_trunc
      assign dout_o = OUT_W'(stg[SH_W]);
   end else begin : g_pad
      assign dout_o = {{(OUT_W-IN_W){1'b0}}, stg[SH_W]};
   end

endmodule

// File: rtl/adc_ovs_ctrl.sv
module adc_ovs_ctrl #(
   parameter int DATA_W    = 12,
   parameter int LOG2_MAX  = 8,
   parameter int ACC_W     = 20,
   parameter int OUT_W     = 16,
   parameter int MAX_SHIFT = 8,
   parameter int SEL_W     = $clog2(LOG2_MAX),
   parameter int SH_W      = $clog2(MAX_SHIFT + 1)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              trig_i,
   input  logic              smp_valid_i,
   input  logic [DATA_W-1:0] smp_data_i,
   input  logic              abort_i,
   input  logic              per_smp_trig_i,
   input  logic              burst_gate_i,
   input  logic              restart_on_abort_i,
   input  logic [SEL_W-1:0]  ratio_sel_i,
   input  logic [SH_W-1:0]   shift_i,
   output logic              conv_start_o,
   output logic [OUT_W-1:0]  avg_o,
   output logic              eoc_o
);

   if (ACC_W < DATA_W + LOG2_MAX) begin : g_chk_acc
      $error("accumulator too narrow for the largest ratio");
   end
   if ((1 << SEL_W) != LOG2_MAX) begin : g_chk_sel
      $error("LOG2_MAX must be a power of two matching SEL_W");
   end
   if (MAX_SHIFT < 1 || (1 << SH_W) <= MAX_SHIFT) begin : g_chk_sh
      $error("shift field width does not cover MAX_SHIFT");
   end

   logic             add_w, clr_w, done_w;
   logic [ACC_W-1:0] sum_w;
   logic [OUT_W-1:0] avg_w;

   adc_ovs_seq u_seq (
      .clk_i              (clk_i),
      .rst_ni             (rst_ni),
      .trig_i             (trig_i),
      .smp_valid_i        (smp_valid_i),
      .abort_i            (abort_i),
      .per_smp_trig_i     (per_smp_trig_i),
      .burst_gate_i       (burst_gate_i),
      .restart_on_abort_i (restart_on_abort_i),
      .done_i             (done_w),
      .start_o            (conv_start_o),
      .add_o              (add_w),
      .clr_o              (clr_w)
   );

   adc_ovs_acc #(
      .DATA_W   (DATA_W),
      .LOG2_MAX (LOG2_MAX),
      .ACC_W    (ACC_W),
      .SEL_W    (SEL_W)
   ) u_acc (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .add_i       (add_w),
      .clr_i       (clr_w),
      .data_i      (smp_data_i),
      .ratio_sel_i (ratio_sel_i),
      .done_o      (done_w),
      .sum_o       (sum_w)
   );

   adc_ovs_shift #(
      .IN_W      (ACC_W),
      .OUT_W     (OUT_W),
      .SH_W      (SH_W),
      .MAX_SHIFT (MAX_SHIFT)
   ) u_shift (
      .din_i  (sum_w),
      .sh_i   (shift_i),
      .dout_o (avg_w)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         avg_o <= '0;
         eoc_o <= 1'b0;
      end else begin
         eoc_o <= done_w;
         if (done_w) avg_o <= avg_w;
      end
   end

   // R4: a result only follows a sample that was actually accepted
   p_eoc_src_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      eoc_o |-> $past(smp_valid_i && !abort_i));

   // R4: the result register moves only with the end-of-conversion pulse
   p_result_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !eoc_o |-> $stable(avg_o));

   // R11: an abort never lets a sample complete a result
   p_abort_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      abort_i |=> !eoc_o);

endmodule

// File: tb/adc_ovs_ctrl_tb.sv
`timescale 1ns/100ps
module adc_ovs_ctrl_tb;

   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic        trig_i = 1'b0;
   logic        smp_valid = 1'b0;
   logic [11:0] smp_data = '0;
   logic        abort_i = 1'b0;
   logic        cfg_pst = 1'b0;
   logic        cfg_gate = 1'b1;
   logic        cfg_rst_mode = 1'b0;
   logic [2:0]  cfg_sel = 3'd1;
   logic [3:0]  cfg_shift = 4'd0;
   logic        conv_start_o;
   logic [15:0] avg_o;
   logic        eoc_o;

   int n_chk = 0, n_fail = 0;
   int n_start = 0, n_eoc = 0;
   string cur_req = "R4";

   always #2.5 clk_i = ~clk_i;

   adc_ovs_ctrl u_dut (
      .clk_i              (clk_i),
      .rst_ni             (rst_ni),
      .trig_i             (trig_i),
      .smp_valid_i        (smp_valid),
      .smp_data_i         (smp_data),
      .abort_i            (abort_i),
      .per_smp_trig_i     (cfg_pst),
      .burst_gate_i       (cfg_gate),
      .restart_on_abort_i (cfg_rst_mode),
      .ratio_sel_i        (cfg_sel),
      .shift_i            (cfg_shift),
      .conv_start_o       (conv_start_o),
      .avg_o              (avg_o),
      .eoc_o              (eoc_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Converter model: fixed latency, drops a conversion on abort
   localparam int LAT = 2;
   logic busy = 1'b0;
   int   cd = 0;
   int   k = 0;
   always @(posedge clk_i) begin
      if (!rst_ni) begin
         busy <= 1'b0; smp_valid <= 1'b0; cd <= 0;
      end else begin
         smp_valid <= 1'b0;
         if (abort_i) busy <= 1'b0;
         else if (conv_start_o) begin busy <= 1'b1; cd <= LAT - 1; end
         else if (busy) begin
            if (cd == 0) begin
               smp_valid <= 1'b1;
               smp_data  <= 12'((k * 97) + 13);
               k         <= k + 1;
               busy      <= 1'b0;
            end else cd <= cd - 1;
         end
      end
   end

   // Expected-sum model built from accepted samples and aborts
   int sb_acc = 0, sb_cnt = 0, exp_res = 0;
   bit exp_eoc = 1'b0;
   always @(posedge clk_i) begin
      if (!rst_ni) begin
         sb_acc = 0; sb_cnt = 0; exp_eoc = 1'b0;
      end else begin
         exp_eoc = 1'b0;
         if (abort_i) begin
            if (cfg_rst_mode) begin sb_acc = 0; sb_cnt = 0; end
         end else if (smp_valid) begin
            sb_acc += int'(smp_data);
            sb_cnt++;
            if (sb_cnt == (1 << (int'(cfg_sel) + 1))) begin
               exp_eoc = 1'b1;
               exp_res = int'(16'(sb_acc >> ((cfg_shift > 4'd8) ? 8 : int'(cfg_shift))));
               sb_acc = 0; sb_cnt = 0;
            end
         end
      end
   end

   always @(negedge clk_i) begin
      if (rst_ni) begin
         if (conv_start_o) n_start++;
         if (eoc_o) n_eoc++;
         if (eoc_o || exp_eoc) begin
            chk(eoc_o == exp_eoc, {cur_req, " eoc"}, int'(eoc_o), int'(exp_eoc));
            if (exp_eoc) chk(int'(avg_o) == exp_res, {cur_req, " R10 result"}, int'(avg_o), exp_res);
         end
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk_i);
   endtask

   task automatic trig_pulse();
      @(negedge clk_i) trig_i = 1'b1;
      @(negedge clk_i) trig_i = 1'b0;
   endtask

   task automatic setup(input bit pst, input bit gate, input bit rmode,
                        input logic [2:0] sel, input logic [3:0] sh, input string req);
      @(negedge clk_i);
      cfg_pst = pst; cfg_gate = gate; cfg_rst_mode = rmode;
      cfg_sel = sel; cfg_shift = sh; cur_req = req;
   endtask

   task automatic wait_valid();
      do @(negedge clk_i); while (!smp_valid);
   endtask

   task automatic t_reset();
      rst_ni = 1'b0;
      cyc(4);
      rst_ni = 1'b1;
      cyc(1);
      chk(eoc_o == 1'b0, "R4 reset eoc", int'(eoc_o), 0);
      chk(avg_o == 16'd0, "R4 reset result", int'(avg_o), 0);
      chk(conv_start_o == 1'b0, "R2 reset start", int'(conv_start_o), 0);
   endtask

   task automatic t_burst();
      int s0, e0;
      setup(1'b0, 1'b1, 1'b0, 3'd1, 4'd2, "R2");
      s0 = n_start; e0 = n_eoc;
      trig_pulse();
      cyc(3);
      trig_pulse();            // R12: arrives mid-conversion, ignored
      cyc(40);
      chk(n_start - s0 == 4, "R2 R12 starts per trigger", n_start - s0, 4);
      chk(n_eoc - e0 == 1, "R4 one result per burst", n_eoc - e0, 1);
   endtask

   task automatic t_per_sample();
      int s0, e0;
      setup(1'b1, 1'b0, 1'b0, 3'd1, 4'd2, "R3");
      s0 = n_start; e0 = n_eoc;
      trig_pulse();
      cyc(20);
      chk(n_start - s0 == 1, "R1 R3 one start per trigger", n_start - s0, 1);
      chk(n_eoc - e0 == 0, "R4 no result after one sample", n_eoc - e0, 0);
      for (int i = 0; i < 3; i++) begin
         trig_pulse();
         cyc(20);
      end
      chk(n_start - s0 == 4, "R3 four triggers four starts", n_start - s0, 4);
      chk(n_eoc - e0 == 1, "R4 result after fourth sample", n_eoc - e0, 1);
   endtask

   task automatic t_free_run();
      int e0, e1;
      setup(1'b0, 1'b0, 1'b0, 3'd0, 4'd1, "R8");
      e0 = n_eoc;
      trig_pulse();
      cyc(40);
      chk(n_eoc - e0 >= 3, "R8 bursts repeat", n_eoc - e0, 3);
      @(negedge clk_i) cfg_gate = 1'b1;
      cyc(20);
      e1 = n_eoc;
      cyc(30);
      chk(n_eoc == e1, "R8 repetition stops", n_eoc - e1, 0);
   endtask

   task automatic t_keep_on_abort();
      int s0, e0;
      setup(1'b0, 1'b1, 1'b0, 3'd1, 4'd3, "R5 R11");
      s0 = n_start; e0 = n_eoc;
      trig_pulse();
      wait_valid();
      wait_valid();
      abort_i = 1'b1;           // R11: lands on the strobe cycle
      @(negedge clk_i) abort_i = 1'b0;
      cyc(40);
      chk(n_start - s0 == 5, "R5 R11 one reissued request", n_start - s0, 5);
      chk(n_eoc - e0 == 1, "R5 result still produced", n_eoc - e0, 1);
   endtask

   task automatic t_clear_on_abort();
      int s0, e0;
      setup(1'b0, 1'b1, 1'b1, 3'd1, 4'd0, "R6");
      s0 = n_start; e0 = n_eoc;
      trig_pulse();
      wait_valid();
      wait_valid();
      @(negedge clk_i) abort_i = 1'b1;  // conversion in flight
      @(negedge clk_i) abort_i = 1'b0;
      cyc(40);
      chk(n_start - s0 == 7, "R6 restart needs four fresh samples", n_start - s0, 7);
      chk(n_eoc - e0 == 1, "R6 one result", n_eoc - e0, 1);
   endtask

   task automatic t_starve();
      int s0, e0;
      setup(1'b0, 1'b1, 1'b1, 3'd1, 4'd0, "R7");
      s0 = n_start; e0 = n_eoc;
      trig_pulse();
      for (int i = 0; i < 40; i++) begin
         cyc(5);
         abort_i = 1'b1;
         @(negedge clk_i) abort_i = 1'b0;
      end
      chk(n_eoc - e0 == 0, "R7 no result under abort train", n_eoc - e0, 0);
      chk(n_start - s0 > 20, "R7 requests continue", n_start - s0, 21);
      cyc(40);
      chk(n_eoc - e0 == 1, "R7 result once aborts stop", n_eoc - e0, 1);
   endtask

   task automatic t_ratio(input logic [2:0] sel, input logic [3:0] sh);
      int s0, e0, n;
      n = 1 << (int'(sel) + 1);
      setup(1'b0, 1'b1, 1'b0, sel, sh, "R9 R10");
      s0 = n_start; e0 = n_eoc;
      trig_pulse();
      cyc(n * 4 + 20);
      chk(n_start - s0 == n, "R9 starts equal ratio", n_start - s0, n);
      chk(n_eoc - e0 == 1, "R9 one result", n_eoc - e0, 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk_i);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_burst();
      t_per_sample();
      t_free_run();
      t_keep_on_abort();
      t_clear_on_abort();
      t_starve();
      t_ratio(3'd7, 4'd8);
      t_ratio(3'd7, 4'd0);
      t_ratio(3'd0, 4'd15);
      t_ratio(3'd2, 4'd3);
      cyc(5);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule